// File: doc/BRIEF.md
# Procedure Return Frame Unwinder

This block carries out the stack-unwinding half of a procedure return. Given the current frame pointer, it points the stack pointer just past the frame base. It then reads a packed control word off the stack. That word says how much alignment padding to drop, whether an argument list must be discarded, which general registers were saved, and what the saved status word was. From it the block works out a pop sequence of variable length.

Every pop reads one 32-bit word at the working stack pointer through a read port with a one-cycle latency, then steps the pointer by 4. The block first pops the return PC, frame pointer and argument pointer. It then restores the saved general registers through a register-file write port. Next it adds the alignment padding and takes the saved status word. If the frame came from a call with an argument count on the stack, it pops that count and skips the list. The final stack pointer, PC, frame pointer, argument pointer and status word all appear at once, marked by a one-cycle completion pulse. A control word with a nonzero reserved byte stops the sequence with a fault pulse.

Top module: `frame_unwinder`

## Requirements
- R1: After a synchronous active-low reset, sp_out, pc_out, fp_out, ap_out and psw_out are zero, and busy, done, fault, mem_rd and rf_we are low.
- R2: A start seen while idle makes the first memory read go to address fp_in + 4. Each later pop reads at the working stack pointer, which then grows by 4. Read data is taken exactly one cycle after mem_rd.
- R3: The first word popped is the control word. The next three pops, in order, give the values reported on pc_out, fp_out and ap_out.
- R4: Bits 27:16 of the control word are a restore mask. For each set bit i, one word is popped and written to register i (rf_waddr = i, rf_wdata = popped word), in ascending order of i from bit 0 to bit 11. No other register writes happen.
- R5: After the restores, the working stack pointer grows by the unsigned value of control-word bits 31:30.
- R6: psw_out receives control-word bits 15:0. Bits 3, 2, 1 and 0 therefore restore N, Z, V and C.
- R7: When control-word bit 29 is 1, one more word is popped after the alignment step. The stack pointer then grows by 4 times bit field 7:0 of that word, and bits 31:8 of that word have no effect. When bit 29 is 0, no such pop occurs.
- R8: Control-word bit 28 has no effect on any output.
- R9: If control-word bits 15:8 are nonzero, fault pulses high for one cycle right after the control-word read. In that case no register is written, done does not pulse, and all five result outputs keep their previous values.
- R10: done is high for exactly one cycle. In that cycle all five result outputs hold the final values, and busy is already low.
- R11: start is ignored while busy is high, including any change of fp_in during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an unwind (taken only when idle) |
| fp_in | input | 32 | Current frame pointer at start |
| mem_rd | output | 1 | Read request for one stack word |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| rf_we | output | 1 | General-register write enable |
| rf_waddr | output | 4 | Register number being restored |
| rf_wdata | output | 32 | Value being restored |
| sp_out | output | 32 | Final stack pointer |
| pc_out | output | 32 | Restored PC |
| fp_out | output | 32 | Restored frame pointer |
| ap_out | output | 32 | Restored argument pointer |
| psw_out | output | 16 | Restored status word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle reserved-operand fault pulse |

## Verification
The hardest case to reach from the ports is the order in which stack data is consumed when every variant stacks up together. A full 12-register mask, a nonzero alignment and an argument-count pop all shift the address of every later word, and a small error hides in the final pointer unless each position carries a distinct value. The bench builds each frame in a word memory model from the control word alone, giving each slot a unique tag. It then checks every register write and every final value against that layout. It also includes a frame with an argument count whose upper bits are set, a reserved-byte fault that follows a good run, and a second start with a different frame pointer fired mid-run.

// File: rtl/frd_pkg.sv
// Package: shared constants and types for the frame unwinder.
// Assumes a 32-bit word, byte addressing and a 12-bit restore mask.
package frd_pkg;
    localparam int WORD_W    = 32;
    localparam int NREG      = 12;
    localparam int IDX_W     = $clog2(NREG);
    localparam int PSW_W     = 16;
    localparam int WORD_B    = WORD_W / 8;
    localparam int ALIGN_W   = 2;
    localparam int CNT_W     = 8;

    // Control-word field positions (decoded by neighbouring logic)
    localparam int ALIGN_LSB = 30;
    localparam int FLAG_BIT  = 29;
    localparam int MASK_LSB  = 16;
    localparam int RSVD_LSB  = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_TAKE, S_ALIGN, S_FIN
    } state_t;

    typedef enum logic [2:0] {
        IT_DESC, IT_PC, IT_FP, IT_AP, IT_REG, IT_ARGC
    } item_t;

    typedef struct packed {
        logic [ALIGN_W-1:0] align;
        logic               argpop;
        logic [NREG-1:0]    mask;
        logic [PSW_W-1:0]   psw;
        logic               rsvd;
    } desc_t;
endpackage

// File: rtl/frd_desc_decode.sv
// Module: splits a frame control word into its fields and flags
// a nonzero reserved byte. Purely combinational; bit 28 is not read.
module frd_desc_decode
    import frd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output desc_t             desc_o
);
    // Field extraction at fixed positions
    always_comb begin
        desc_o.align  = word_i[ALIGN_LSB +: ALIGN_W];
        desc_o.argpop = word_i[FLAG_BIT];
        desc_o.mask   = word_i[MASK_LSB +: NREG];
        desc_o.psw    = word_i[PSW_W-1:0];
        desc_o.rsvd   = |word_i[PSW_W-1:RSVD_LSB];
    end
endmodule

// File: rtl/frd_mask_scan.sv
// Module: finds the lowest set bit of a mask. Assumes N >= 2.
// Reports found=0 and idx=0 for an empty mask.
module frd_mask_scan #(
    parameter int N   = 12,
    parameter int IW  = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Descending walk so the lowest set bit wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/frame_unwinder.sv
// Module: top of the procedure-return unwinder. Sequences pops through
// a one-cycle-latency read port: control word, PC, FP, AP, masked
// registers, alignment, optional argument-count pop. Results are
// committed together with a done pulse. Assumes the memory never stalls.
module frame_unwinder
    import frd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       fp_in,
    output logic              mem_rd,
    output logic [31:0]       mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              rf_we,
    output logic [3:0]        rf_waddr,
    output logic [31:0]       rf_wdata,
    output logic [31:0]       sp_out,
    output logic [31:0]       pc_out,
    output logic [31:0]       fp_out,
    output logic [31:0]       ap_out,
    output logic [15:0]       psw_out,
    output logic              busy,
    output logic              done,
    output logic              fault
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_B);

    state_t             state;
    item_t              item;
    logic [WORD_W-1:0]  sp_w, pc_w, fp_w, ap_w, desc_q;
    logic [PSW_W-1:0]   psw_w;
    logic [NREG-1:0]    rem_mask, scan_in, cur_onehot;
    logic [IDX_W-1:0]   cur_idx, scan_idx;
    logic               scan_found;
    logic               taking, take_desc, take_reg;
    logic [WORD_W-1:0]  dec_word;
    desc_t              dec;

    assign taking    = (state == S_TAKE);
    assign take_desc = taking && (item == IT_DESC);
    assign take_reg  = taking && (item == IT_REG);

    // Decoder looks at fresh data while it arrives, else at the held copy
    assign dec_word = take_desc ? mem_rdata : desc_q;

    frd_desc_decode u_dec (
        .word_i (dec_word),
        .desc_o (dec)
    );

    // Mask for the next scan, dropping the register being restored now
    always_comb begin
        cur_onehot = '0;
        cur_onehot[cur_idx] = 1'b1;
        scan_in = take_reg ? (rem_mask & ~cur_onehot) : rem_mask;
    end

    frd_mask_scan #(.N(NREG), .IW(IDX_W)) u_scan (
        .bits_i  (scan_in),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    // Port-side views of the sequencer
    assign busy     = (state != S_IDLE);
    assign mem_rd   = (state == S_ISSUE);
    assign mem_addr = sp_w;
    assign rf_we    = take_reg;
    assign rf_waddr = 4'(cur_idx);
    assign rf_wdata = mem_rdata;

    // Main sequencer: pop order, pointer arithmetic and result commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            item     <= IT_DESC;
            sp_w     <= '0;
            pc_w     <= '0;
            fp_w     <= '0;
            ap_w     <= '0;
            desc_q   <= '0;
            psw_w    <= '0;
            rem_mask <= '0;
            cur_idx  <= '0;
            sp_out   <= '0;
            pc_out   <= '0;
            fp_out   <= '0;
            ap_out   <= '0;
            psw_out  <= '0;
            done     <= 1'b0;
            fault    <= 1'b0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        sp_w  <= fp_in + STEP;
                        item  <= IT_DESC;
                        state <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    state <= S_TAKE;
                end
                S_TAKE: begin
                    unique case (item)
                        IT_DESC: begin
                            desc_q <= mem_rdata;
                            if (dec.rsvd) begin
                                fault <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                sp_w     <= sp_w + STEP;
                                rem_mask <= dec.mask;
                                item     <= IT_PC;
                                state    <= S_ISSUE;
                            end
                        end
                        IT_PC: begin
                            pc_w  <= mem_rdata;
                            sp_w  <= sp_w + STEP;
                            item  <= IT_FP;
                            state <= S_ISSUE;
                        end
                        IT_FP: begin
                            fp_w  <= mem_rdata;
                            sp_w  <= sp_w + STEP;
                            item  <= IT_AP;
                            state <= S_ISSUE;
                        end
                        IT_AP, IT_REG: begin
                            if (item == IT_AP) ap_w <= mem_rdata;
                            sp_w     <= sp_w + STEP;
                            rem_mask <= scan_in;
                            if (scan_found) begin
                                cur_idx <= scan_idx;
                                item    <= IT_REG;
                                state   <= S_ISSUE;
                            end else begin
                                state   <= S_ALIGN;
                            end
                        end
                        IT_ARGC: begin
                            sp_w  <= sp_w + STEP
                                     + {{(WORD_W-CNT_W-2){1'b0}}, mem_rdata[CNT_W-1:0], 2'b00};
                            state <= S_FIN;
                        end
                        default: state <= S_IDLE;
                    endcase
                end
                S_ALIGN: begin
                    sp_w  <= sp_w + WORD_W'(dec.align);
                    psw_w <= dec.psw;
                    if (dec.argpop) begin
                        item  <= IT_ARGC;
                        state <= S_ISSUE;
                    end else begin
                        state <= S_FIN;
                    end
                end
                S_FIN: begin
                    sp_out  <= sp_w;
                    pc_out  <= pc_w;
                    fp_out  <= fp_w;
                    ap_out  <= ap_w;
                    psw_out <= psw_w;
                    done    <= 1'b1;
                    state   <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!done && !rf_we));

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R6
    psw_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (psw_out[15:8] == 8'h00));

    // R4
    scan_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr < 4'(NREG)));
endmodule

// File: tb/frame_unwinder_tb.sv
module frame_unwinder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    // {fp, control word, argument-count word}
    localparam logic [95:0] VECS [NV] = '{
        {32'h0000_0100, 32'h0000_000F, 32'h0000_0000},
        {32'h0000_0140, 32'hE801_0005, 32'hFFFF_FF02},
        {32'h0000_0200, 32'h5FFF_000A, 32'h0000_0000},
        {32'h0000_0080, 32'hA0A4_0008, 32'h1234_5600}
    };

    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [31:0] fp_in, mem_addr, mem_rdata, rf_wdata;
    logic        mem_rd, rf_we, busy, done, fault;
    logic [3:0]  rf_waddr;
    logic [31:0] sp_out, pc_out, fp_out, ap_out;
    logic [15:0] psw_out;

    logic [31:0] mem [256];
    int pass_cnt = 0;
    int fail_cnt = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_unwinder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fp_in(fp_in),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .sp_out(sp_out), .pc_out(pc_out), .fp_out(fp_out), .ap_out(ap_out),
        .psw_out(psw_out), .busy(busy), .done(done), .fault(fault)
    );

    // Word memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] reg_val(input int v, input int r);
        return 32'h5A00_0000 | (32'(r) << 8) | 32'(v);
    endfunction

    // Observed results of one run
    logic [31:0] wr_val [12];
    logic [11:0] wr_seen;
    int          wr_cnt;
    bit          order_bad, saw_done, saw_fault, done_twice;
    logic [31:0] first_addr;

    // Build the frame, start, and watch the ports until done or fault
    task automatic run(input int v, input logic [31:0] fp, input logic [31:0] dw,
                       input logic [31:0] aw, input bit late_start);
        logic [31:0] a;
        int last = -1;
        bit got_first = 0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        a = fp + 4;
        mem[a[9:2]] = dw;                  a += 4;
        mem[a[9:2]] = 32'hC0DE_0000 | 32'(v); a += 4;
        mem[a[9:2]] = 32'hF0F0_0000 | 32'(v); a += 4;
        mem[a[9:2]] = 32'hA0A0_0000 | 32'(v); a += 4;
        for (int r = 0; r < 12; r++) if (dw[16 + r]) begin
            mem[a[9:2]] = reg_val(v, r); a += 4;
        end
        a += 32'(dw[31:30]);
        if (dw[29]) mem[a[9:2]] = aw;
        wr_seen = '0; wr_cnt = 0; order_bad = 0; saw_done = 0; saw_fault = 0; done_twice = 0;
        first_addr = 'x;
        for (int r = 0; r < 12; r++) wr_val[r] = 'x;
        @(negedge clk); start = 1; fp_in = fp;
        @(negedge clk); start = 0;
        for (int c = 0; c < 200; c++) begin
            if (late_start && c == 3) begin start = 1; fp_in = fp + 32'h40; end
            if (late_start && c == 4) start = 0;
            if (mem_rd && !got_first) begin got_first = 1; first_addr = mem_addr; end
            if (rf_we) begin
                if (int'(rf_waddr) <= last) order_bad = 1;
                last = int'(rf_waddr);
                wr_cnt++;
                if (rf_waddr < 12) begin wr_seen[rf_waddr] = 1; wr_val[rf_waddr] = rf_wdata; end
            end
            if (fault) saw_fault = 1;
            if (done) begin
                saw_done = 1;
                @(negedge clk);
                if (done) done_twice = 1;
                break;
            end
            if (saw_fault) begin
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk);
                    if (done) saw_done = 1;
                    if (rf_we) wr_cnt++;
                end
                break;
            end
            @(negedge clk);
        end
    endtask

    // Check a completed run against the layout implied by the control word
    task automatic check_run(input int v, input logic [31:0] fp, input logic [31:0] dw, input logic [31:0] aw);
        logic [31:0] esp;
        int np = 0;
        for (int r = 0; r < 12; r++) if (dw[16 + r]) np++;
        esp = fp + 4 + 16 + 32'(4 * np) + 32'(dw[31:30]);
        if (dw[29]) esp += 4 + {22'd0, aw[7:0], 2'b00};
        chk(saw_done && !saw_fault, "R10 run completes", {31'd0, saw_done}, 32'd1);
        chk(!done_twice, "R10 done one cycle", {31'd0, done_twice}, 32'd0);
        chk(!busy, "R10 busy low after done", {31'd0, busy}, 32'd0);
        chk(first_addr == fp + 4, "R2 first read address", first_addr, fp + 4);
        chk(pc_out == (32'hC0DE_0000 | 32'(v)), "R3 pc_out", pc_out, 32'hC0DE_0000 | 32'(v));
        chk(fp_out == (32'hF0F0_0000 | 32'(v)), "R3 fp_out", fp_out, 32'hF0F0_0000 | 32'(v));
        chk(ap_out == (32'hA0A0_0000 | 32'(v)), "R3 ap_out", ap_out, 32'hA0A0_0000 | 32'(v));
        chk(psw_out == dw[15:0], "R6 psw_out", {16'd0, psw_out}, {16'd0, dw[15:0]});
        chk(sp_out == esp, "R5 R7 final sp", sp_out, esp);
        chk(wr_seen == dw[27:16] && wr_cnt == np, "R4 restore set", {20'd0, wr_seen}, {20'd0, dw[27:16]});
        chk(!order_bad, "R4 ascending order", {31'd0, order_bad}, 32'd0);
        for (int r = 0; r < 12; r++) if (dw[16 + r])
            chk(wr_val[r] == reg_val(v, r), "R4 restored value", wr_val[r], reg_val(v, r));
    endtask

    initial begin
        logic [31:0] old_sp, old_pc;
        logic [15:0] old_psw;
        rst_n = 0; start = 0; fp_in = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sp_out == 0 && pc_out == 0 && fp_out == 0 && ap_out == 0 && psw_out == 0,
            "R1 reset outputs", sp_out | pc_out | fp_out | ap_out, 32'd0);
        chk(!busy && !done && !fault && !mem_rd && !rf_we, "R1 reset flags",
            {27'd0, busy, done, fault, mem_rd, rf_we}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // Vector table: R3 R5 R6 R7 (vector 1 has argument-count bits 31:8 set), R8 (vector 2 sets bit 28)
        for (int v = 0; v < NV; v++) begin
            run(v, VECS[v][95:64], VECS[v][63:32], VECS[v][31:0], 1'b0);
            check_run(v, VECS[v][95:64], VECS[v][63:32], VECS[v][31:0]);
        end

        // R8: same frame as vector 2 with bit 28 cleared gives identical results
        run(2, 32'h200, 32'h4FFF_000A, 32'h0, 1'b0);
        check_run(2, 32'h200, 32'h4FFF_000A, 32'h0);

        // R11: second start with another fp mid-run is ignored
        run(1, VECS[1][95:64], VECS[1][63:32], VECS[1][31:0], 1'b1);
        check_run(1, VECS[1][95:64], VECS[1][63:32], VECS[1][31:0]);

        // R9: reserved byte nonzero
        old_sp = sp_out; old_pc = pc_out; old_psw = psw_out;
        run(7, 32'h300, 32'h2003_0100, 32'h0, 1'b0);
        chk(saw_fault, "R9 fault pulse", {31'd0, saw_fault}, 32'd1);
        chk(!saw_done, "R9 no done", {31'd0, saw_done}, 32'd0);
        chk(wr_cnt == 0, "R9 no register writes", 32'(wr_cnt), 32'd0);
        chk(sp_out == old_sp && pc_out == old_pc && psw_out == old_psw,
            "R9 results unchanged", sp_out, old_sp);
        chk(!busy && !fault, "R9 back to idle", {30'd0, busy, fault}, 32'd0);

        // Good run after a fault
        run(3, VECS[3][95:64], VECS[3][63:32], VECS[3][31:0], 1'b0);
        check_run(3, VECS[3][95:64], VECS[3][63:32], VECS[3][31:0]);

        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end
endmodule